// File: doc/BRIEF.md
# DDR SDRAM Bank Command Sequencer

This block sits between a simple request port and the command/address pins of a four-bank double-data-rate SDRAM. Each request carries a flat word address, a read/write flag and an auto-precharge flag. The block splits the address into bank, row and column fields. It keeps a record of which row is open in each bank. It then emits the shortest legal command sequence for the request: a column command alone when the row is already open, ACTIVE then the column command when the bank is idle, and PRECHARGE, ACTIVE and then the column command when a different row is open.

The gaps between commands follow one of two speed grades, chosen by a static input: 3-3-3 or 3-4-4 for CAS latency, ACTIVE-to-column delay and PRECHARGE-to-ACTIVE delay. Auto-precharge is requested by driving address bit 10 high on the column command. A read-window output marks the clock cycles in which the read burst returns. The data path, mode-register programming and the electrical interface belong to other blocks.

Top module: `ddr_bank_seq`

## Requirements
- R1: After reset the bus carries NOP, req_ready is high, rd_valid is low and every bank is treated as closed.
- R2: The flat address is {row[12:0], bank[1:0], col[COL_W-1:0]}. An ACTIVE drives the row on cmd_a and the bank on cmd_ba. Every command drives the bank of its request on cmd_ba.
- R3: The encodings of {cs_n, ras_n, cas_n, we_n} are NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100 and PRECHARGE 0010. NOP is driven in every cycle that issues no command.
- R4: A request to a closed bank puts ACTIVE on the bus in the cycle after acceptance. The column command follows tRCD cycles after the ACTIVE.
- R5: A request to the open row of its bank puts the column command on the bus in the cycle after acceptance, with no ACTIVE.
- R6: A request to a bank with a different open row first issues PRECHARGE with cmd_a[10]=0. ACTIVE follows tRP cycles later, and the column command follows tRCD cycles after the ACTIVE.
- R7: With grade_slow=0, tRCD and tRP are both 3 cycles. With grade_slow=1, both are 4 cycles. The grade is taken at acceptance.
- R8: A column command carries the column on cmd_a[COL_W-1:0] and the auto-precharge flag on cmd_a[10]. All other cmd_a bits are zero.
- R9: A column command with auto-precharge closes its bank, so the next request to that bank starts with ACTIVE. req_ready stays low until BURST_LEN/2 + tRP cycles after that column command.
- R10: rd_valid is high for BURST_LEN/2 consecutive cycles, starting exactly CAS_LAT cycles after a READ appears on the bus. Writes never raise rd_valid.
- R11: req_ready is low while a sequence is in progress. After a column command without auto-precharge, the next column command can appear no sooner than BURST_LEN/2 cycles later. A request offered while req_ready is low has no effect on the bus.
- R12: Opening or closing a row in one bank leaves the open rows of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| grade_slow | input | 1 | 0 selects 3-3-3 timing, 1 selects 3-4-4 |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_ap | input | 1 | Close the row after this access (auto-precharge) |
| req_addr | input | ROW_W+BANK_W+COL_W | Flat word address {row, bank, col} |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_ba | output | BANK_W | Bank address |
| cmd_a | output | ROW_W | Row/column address, bit 10 carries auto-precharge |
| rd_valid | output | 1 | Read burst data expected in this cycle |

## Verification
The bench targets the three paths a request can take, in both speed grades. A design that counts tRCD or tRP one cycle short or long puts ACTIVE or the column command in the wrong cycle. A design that forgets the open row re-activates on a hit, or skips the PRECHARGE on a miss. Auto-precharge is checked by following it with a request to the same row: a design that still marks the row open issues a bare column command there. That design, or one that drops bit 10, is reported. A design that leaks one bank's row state into another misclassifies the bank-independence case. A request held on the port while the block is busy must leave the bus untouched, which catches a handshake that accepts early.

// File: rtl/ddr_seq_pkg.sv
// Shared command encodings and sequencer states for the SDRAM command sequencer.
// Assumes a single-rank device addressed through chip-select, RAS, CAS and WE.
package ddr_seq_pkg;

    // {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_NOP = 4'b0111,
        CMD_ACT = 4'b0011,
        CMD_RD  = 4'b0101,
        CMD_WR  = 4'b0100,
        CMD_PRE = 4'b0010
    } ddr_cmd_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_RP,
        S_RCD,
        S_GAP
    } seq_state_e;

    // Address line that carries the auto-precharge flag on column commands.
    localparam int AP_BIT = 10;

endpackage

// File: rtl/ddr_addr_split.sv
// Splits a flat word address into row, bank and column fields.
// Assumes the layout {row, bank, col}, column in the least significant bits.
module ddr_addr_split #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2,
    parameter int COL_W  = 10
) (
    input  logic [ROW_W+BANK_W+COL_W-1:0] addr,
    output logic [ROW_W-1:0]              row,
    output logic [BANK_W-1:0]             bank,
    output logic [COL_W-1:0]              col
);
    localparam int BANK_LSB = COL_W;
    localparam int ROW_LSB  = COL_W + BANK_W;

    // Pure field slicing.
    always_comb begin
        col  = addr[COL_W-1:0];
        bank = addr[BANK_LSB +: BANK_W];
        row  = addr[ROW_LSB +: ROW_W];
    end
endmodule

// File: rtl/ddr_row_tracker.sv
// Keeps one open/closed flag and one row register per bank.
// Assumes that open and close never target the same bank in one cycle.
module ddr_row_tracker #(
    parameter int ROW_W  = 13,
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] lk_bank,
    input  logic [ROW_W-1:0]  lk_row,
    output logic              lk_open,
    output logic              lk_hit,
    input  logic              act_en,
    input  logic [BANK_W-1:0] act_bank,
    input  logic [ROW_W-1:0]  act_row,
    input  logic              close_en,
    input  logic [BANK_W-1:0] close_bank
);
    localparam int NBANK = 1 << BANK_W;

    logic [NBANK-1:0] open_q;
    logic [ROW_W-1:0] row_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        // Per-bank state: set by ACTIVE, cleared by precharge of this bank.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[b] <= 1'b0;
                row_q[b]  <= '0;
            end else if (act_en && act_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b1;
                row_q[b]  <= act_row;
            end else if (close_en && close_bank == BANK_W'(b)) begin
                open_q[b] <= 1'b0;
            end
        end
    end

    // Lookup of the bank under consideration.
    always_comb begin
        lk_open = open_q[lk_bank];
        lk_hit  = open_q[lk_bank] && (row_q[lk_bank] == lk_row);
    end

    // R12
    act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_en |=> open_q[$past(act_bank)]);

endmodule

// File: rtl/ddr_rd_window.sv
// Produces the read-data window: high CAS_LAT cycles after a READ, for BEATS cycles.
// Assumes reads are spaced at least BURST_LEN/2 cycles apart, and CAS_LAT >= 2.
module ddr_rd_window #(
    parameter int CAS_LAT   = 3,
    parameter int BURST_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_fire,
    output logic rd_valid
);
    localparam int BEATS = BURST_LEN / 2;
    localparam int BC_W  = $clog2(BEATS + 1);

    logic [CAS_LAT-1:0] dl_q;
    logic [BC_W-1:0]    bcnt_q;

    // Delay line from the READ decision to the start of the data window.
    always_ff @(posedge clk) begin
        if (!rst_n) dl_q <= '0;
        else        dl_q <= {dl_q[CAS_LAT-2:0], rd_fire};
    end

    // Beat counter that holds the window open for BEATS cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)                bcnt_q <= '0;
        else if (dl_q[CAS_LAT-1])  bcnt_q <= BC_W'(BEATS);
        else if (bcnt_q != '0)     bcnt_q <= bcnt_q - 1'b1;
    end

    assign rd_valid = (bcnt_q != '0);
endmodule

// File: rtl/ddr_seq_fsm.sv
// Sequencer: classifies each accepted request as hit, closed or miss, and steps through
// PRECHARGE / ACTIVE / column commands with the grade-dependent waits.
// Assumes tRCD and tRP are at least 2, and the column field is at most 10 bits wide.
module ddr_seq_fsm
    import ddr_seq_pkg::*;
#(
    parameter int ROW_W      = 13,
    parameter int BANK_W     = 2,
    parameter int COL_W      = 10,
    parameter int BURST_LEN  = 4,
    parameter int TRCD_FAST  = 3,
    parameter int TRCD_SLOW  = 4,
    parameter int TRP_FAST   = 3,
    parameter int TRP_SLOW   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grade_slow,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_ap,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic [BANK_W-1:0] cur_bank,
    output logic [ROW_W-1:0]  cur_row,
    input  logic              trk_open,
    input  logic              trk_hit,
    output logic              fire_act,
    output logic              fire_close,
    output logic              rd_fire,
    output ddr_cmd_e          cmd_q,
    output logic [BANK_W-1:0] ba_q,
    output logic [ROW_W-1:0]  a_q
);
    localparam int BEATS = BURST_LEN / 2;
    localparam int CNT_W = 5;

    seq_state_e        state_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              wr_q, ap_q, slow_q;
    logic [BANK_W-1:0] bank_q;
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;

    logic              accept, fire_pre, fire_col;
    logic              cur_wr, cur_ap, cur_slow;
    logic [COL_W-1:0]  cur_col;
    logic [CNT_W-1:0]  trcd, trp, gap;
    ddr_cmd_e          nxt_cmd;
    logic [ROW_W-1:0]  nxt_a;

    assign req_ready = (state_q == S_IDLE);
    assign accept    = req_valid && req_ready;

    // Fields of the request being worked on: the new one at acceptance, else the held one.
    always_comb begin
        cur_bank = accept ? req_bank   : bank_q;
        cur_row  = accept ? req_row    : row_q;
        cur_col  = accept ? req_col    : col_q;
        cur_wr   = accept ? req_write  : wr_q;
        cur_ap   = accept ? req_ap     : ap_q;
        cur_slow = accept ? grade_slow : slow_q;
        trcd     = cur_slow ? CNT_W'(TRCD_SLOW) : CNT_W'(TRCD_FAST);
        trp      = cur_slow ? CNT_W'(TRP_SLOW)  : CNT_W'(TRP_FAST);
        gap      = CNT_W'(BEATS) + (cur_ap ? trp : '0);
    end

    // Which command, if any, issues at the coming edge.
    always_comb begin
        fire_pre   = accept && trk_open && !trk_hit;
        fire_act   = (accept && !trk_open) || (state_q == S_RP && cnt_q == '0);
        fire_col   = (accept && trk_hit)   || (state_q == S_RCD && cnt_q == '0);
        fire_close = fire_pre || (fire_col && cur_ap);
        rd_fire    = fire_col && !cur_wr;
    end

    // Command and address values for the bus register.
    always_comb begin
        nxt_cmd = CMD_NOP;
        nxt_a   = '0;
        if (fire_pre) begin
            nxt_cmd = CMD_PRE;
        end else if (fire_act) begin
            nxt_cmd = CMD_ACT;
            nxt_a   = cur_row;
        end else if (fire_col) begin
            nxt_cmd = cur_wr ? CMD_WR : CMD_RD;
            nxt_a[COL_W-1:0] = cur_col;
            nxt_a[AP_BIT]    = cur_ap;
        end
    end

    // Holds the accepted request for the later steps of its sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q   <= 1'b0;
            ap_q   <= 1'b0;
            slow_q <= 1'b0;
            bank_q <= '0;
            row_q  <= '0;
            col_q  <= '0;
        end else if (accept) begin
            wr_q   <= req_write;
            ap_q   <= req_ap;
            slow_q <= grade_slow;
            bank_q <= req_bank;
            row_q  <= req_row;
            col_q  <= req_col;
        end
    end

    // State and wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
        end else if (fire_pre) begin
            state_q <= S_RP;
            cnt_q   <= trp - 1'b1;
        end else if (fire_act) begin
            state_q <= S_RCD;
            cnt_q   <= trcd - 1'b1;
        end else if (fire_col) begin
            if (gap == CNT_W'(1)) begin
                state_q <= S_IDLE;
            end else begin
                state_q <= S_GAP;
                cnt_q   <= gap - CNT_W'(2);
            end
        end else if (state_q == S_GAP && cnt_q == '0) begin
            state_q <= S_IDLE;
        end else if (state_q != S_IDLE) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Registered bus outputs; NOP whenever nothing fires.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
            ba_q  <= '0;
            a_q   <= '0;
        end else begin
            cmd_q <= nxt_cmd;
            ba_q  <= cur_bank;
            a_q   <= nxt_a;
        end
    end

    // R4
    act_needs_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_act |-> !trk_open);

    // R5
    col_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire_col |-> trk_hit);

    // R6
    pre_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_PRE) |=> (cmd_q == CMD_NOP));

    // R4
    act_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_q == CMD_ACT) |=> (cmd_q == CMD_NOP));

endmodule

// File: rtl/ddr_bank_seq.sv
// Top of the SDRAM command sequencer: address split, per-bank row tracker,
// command sequencer and read-window generator.
// Assumes one request in flight at a time and a fixed burst length.
module ddr_bank_seq #(
    parameter int ROW_W     = 13,
    parameter int BANK_W    = 2,
    parameter int COL_W     = 10,
    parameter int BURST_LEN = 4,
    parameter int CAS_LAT   = 3,
    parameter int TRCD_FAST = 3,
    parameter int TRCD_SLOW = 4,
    parameter int TRP_FAST  = 3,
    parameter int TRP_SLOW  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          grade_slow,
    input  logic                          req_valid,
    output logic                          req_ready,
    input  logic                          req_write,
    input  logic                          req_ap,
    input  logic [ROW_W+BANK_W+COL_W-1:0] req_addr,
    output logic                          cmd_cs_n,
    output logic                          cmd_ras_n,
    output logic                          cmd_cas_n,
    output logic                          cmd_we_n,
    output logic [BANK_W-1:0]             cmd_ba,
    output logic [ROW_W-1:0]              cmd_a,
    output logic                          rd_valid
);
    import ddr_seq_pkg::*;

    logic [ROW_W-1:0]  s_row, cur_row;
    logic [BANK_W-1:0] s_bank, cur_bank;
    logic [COL_W-1:0]  s_col;
    logic              trk_open, trk_hit, fire_act, fire_close, rd_fire;
    ddr_cmd_e          cmd_q;

    ddr_addr_split #(.ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W)) u_split (
        .addr (req_addr),
        .row  (s_row),
        .bank (s_bank),
        .col  (s_col)
    );

    ddr_row_tracker #(.ROW_W(ROW_W), .BANK_W(BANK_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_bank    (cur_bank),
        .lk_row     (cur_row),
        .lk_open    (trk_open),
        .lk_hit     (trk_hit),
        .act_en     (fire_act),
        .act_bank   (cur_bank),
        .act_row    (cur_row),
        .close_en   (fire_close),
        .close_bank (cur_bank)
    );

    ddr_seq_fsm #(
        .ROW_W(ROW_W), .BANK_W(BANK_W), .COL_W(COL_W), .BURST_LEN(BURST_LEN),
        .TRCD_FAST(TRCD_FAST), .TRCD_SLOW(TRCD_SLOW),
        .TRP_FAST(TRP_FAST), .TRP_SLOW(TRP_SLOW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .grade_slow (grade_slow),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_ap     (req_ap),
        .req_bank   (s_bank),
        .req_row    (s_row),
        .req_col    (s_col),
        .cur_bank   (cur_bank),
        .cur_row    (cur_row),
        .trk_open   (trk_open),
        .trk_hit    (trk_hit),
        .fire_act   (fire_act),
        .fire_close (fire_close),
        .rd_fire    (rd_fire),
        .cmd_q      (cmd_q),
        .ba_q       (cmd_ba),
        .a_q        (cmd_a)
    );

    ddr_rd_window #(.CAS_LAT(CAS_LAT), .BURST_LEN(BURST_LEN)) u_rdw (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_fire  (rd_fire),
        .rd_valid (rd_valid)
    );

    assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;

endmodule

// File: tb/tb_ddr_bank_seq.sv
`timescale 1ns/1ps
module tb_ddr_bank_seq;
    localparam int ROW_W = 13, BANK_W = 2, COL_W = 10;
    localparam int BL = 4, CL = 3, BEATS = BL / 2;
    localparam logic [3:0] E_NOP = 4'b0111, E_ACT = 4'b0011, E_RD = 4'b0101,
                           E_WR = 4'b0100, E_PRE = 4'b0010;

    logic clk = 1'b0, rst_n = 1'b0;
    logic grade_slow = 1'b0, req_valid = 1'b0, req_write = 1'b0, req_ap = 1'b0;
    logic [ROW_W+BANK_W+COL_W-1:0] req_addr = '0;
    logic req_ready, cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n, rd_valid;
    logic [BANK_W-1:0] cmd_ba;
    logic [ROW_W-1:0]  cmd_a;

    int checks = 0, errors = 0;
    logic             mdl_open [4];
    logic [ROW_W-1:0] mdl_row  [4];

    ddr_bank_seq dut (
        .clk(clk), .rst_n(rst_n), .grade_slow(grade_slow),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_ap(req_ap), .req_addr(req_addr),
        .cmd_cs_n(cmd_cs_n), .cmd_ras_n(cmd_ras_n), .cmd_cas_n(cmd_cas_n),
        .cmd_we_n(cmd_we_n), .cmd_ba(cmd_ba), .cmd_a(cmd_a), .rd_valid(rd_valid)
    );

    always #2 clk = ~clk;

    function automatic logic [3:0] bus_cmd();
        return {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One request; the bench model decides hit/closed/miss and the expected timeline.
    task automatic do_req(input bit wr, input bit ap, input logic [1:0] bank,
                          input logic [12:0] row, input logic [9:0] col,
                          input bit slow, input bit junk, input string req);
        int t_rcd, t_rp, c, g, last, act_k, pre_k, guard;
        bit bus_ok, rdy_ok, rv_ok;
        int bad_k, bad_act, bad_exp;
        logic [3:0] colc;
        logic [12:0] col_a;
        t_rcd = slow ? 4 : 3;
        t_rp  = slow ? 4 : 3;
        pre_k = -1; act_k = -1;
        if (!mdl_open[bank])            begin act_k = 0; c = t_rcd; end
        else if (mdl_row[bank] == row)  begin c = 0; end
        else begin pre_k = 0; act_k = t_rp; c = t_rp + t_rcd; end
        g = BEATS + (ap ? t_rp : 0);
        last = (c + g - 1 > c + CL + BEATS) ? c + g - 1 : c + CL + BEATS;
        last = last + 1;
        colc = wr ? E_WR : E_RD;
        col_a = '0; col_a[9:0] = col; col_a[10] = ap;
        guard = 0;
        while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
        req_valid = 1'b1; req_write = wr; req_ap = ap; grade_slow = slow;
        req_addr = {row, bank, col};
        @(posedge clk);
        bus_ok = 1; rdy_ok = 1; rv_ok = 1; bad_k = -1; bad_act = 0; bad_exp = 0;
        for (int k = 0; k <= last; k++) begin
            logic [3:0] ec;
            bit er, ev;
            @(negedge clk);
            if (junk && !req_ready) begin
                req_valid = 1'b1; req_write = 1'b1; req_ap = 1'b1;
                req_addr = {row ^ 13'h155, bank ^ 2'b01, ~col};
            end else begin
                req_valid = 1'b0;
            end
            ec = (k == pre_k) ? E_PRE : (k == act_k) ? E_ACT : (k == c) ? colc : E_NOP;
            if (bus_cmd() != ec) begin
                if (bus_ok) begin bad_k = k; bad_act = bus_cmd(); bad_exp = ec; end
                bus_ok = 0;
            end
            if (ec != E_NOP && cmd_ba != bank) begin
                if (bus_ok) begin bad_k = k; bad_act = cmd_ba; bad_exp = bank; end
                bus_ok = 0;
            end
            if ((k == act_k && cmd_a != row) || (k == pre_k && cmd_a[10] != 1'b0) ||
                (k == c && cmd_a != col_a)) begin
                if (bus_ok) begin bad_k = k; bad_act = cmd_a; bad_exp = (k == c) ? col_a : row; end
                bus_ok = 0;
            end
            er = (k >= c + g - 1);
            if (req_ready != er) rdy_ok = 0;
            ev = !wr && (k >= c + CL) && (k < c + CL + BEATS);
            if (rd_valid != ev) rv_ok = 0;
        end
        req_valid = 1'b0;
        check(bus_ok, req, $sformatf("bus sequence at cycle %0d", bad_k), bad_act, bad_exp);
        check(rdy_ok, junk ? {req, "/R11"} : {req, "/R11 ready"}, "req_ready timing", 0, 1);
        check(rv_ok, wr ? {req, "/R10 write"} : {req, "/R10"}, "rd_valid window", 0, 1);
        if (ap) mdl_open[bank] = 1'b0;
        else begin mdl_open[bank] = 1'b1; mdl_row[bank] = row; end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(bus_cmd() == E_NOP, "R1", "bus after reset", bus_cmd(), E_NOP);
        check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        check(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    endtask

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int b = 0; b < 4; b++) begin mdl_open[b] = 1'b0; mdl_row[b] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        // R4 R2 R10: closed bank, fast grade
        do_req(1'b0, 1'b0, 2'd0, 13'h0ABC, 10'h3FF, 1'b0, 1'b0, "R4 closed-read");
        // R5: hit on the open row
        do_req(1'b0, 1'b0, 2'd0, 13'h0ABC, 10'h001, 1'b0, 1'b0, "R5 hit-read");
        // R6 R3: miss, write
        do_req(1'b1, 1'b0, 2'd0, 13'h1F00, 10'h155, 1'b0, 1'b0, "R6 miss-write");
        // R7: slow grade closed then miss
        do_req(1'b0, 1'b0, 2'd1, 13'h0001, 10'h010, 1'b1, 1'b0, "R7 slow-closed");
        do_req(1'b0, 1'b0, 2'd1, 13'h1FFF, 10'h020, 1'b1, 1'b0, "R7 slow-miss");
        // R12: bank 0 still holds its row after bank 1 activity
        do_req(1'b1, 1'b0, 2'd0, 13'h1F00, 10'h2AA, 1'b0, 1'b0, "R12 other-bank-hit");
        // R9 R8: auto-precharge then the same row must re-activate
        do_req(1'b0, 1'b0, 2'd2, 13'h0777, 10'h000, 1'b0, 1'b0, "R9 open");
        do_req(1'b0, 1'b1, 2'd2, 13'h0777, 10'h2C3, 1'b0, 1'b0, "R8 ap-read");
        do_req(1'b0, 1'b0, 2'd2, 13'h0777, 10'h004, 1'b0, 1'b0, "R9 after-ap");
        // R11: request held while busy is ignored
        do_req(1'b0, 1'b0, 2'd3, 13'h0042, 10'h080, 1'b0, 1'b1, "R11 busy-ignore");
        do_req(1'b1, 1'b1, 2'd3, 13'h0999, 10'h300, 1'b1, 1'b1, "R11 busy-ignore-slow");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule